// File: doc/BRIEF.md
# Device Status Register with Edge-Latched Interrupt Request

This block is one device's control/status register together with the logic that turns the register's flags into an interrupt request line. Software reaches the register over a small bus. A select line marks an access to it, a write strobe carries data in, and read data comes back combinationally. Four bits are visible: error summary, ready, interrupt enable and a start bit. Ready and error come from the device side and are read-only. Software controls enable and start. Writing start as 1 gives the device a one-cycle start pulse.

The interrupt request comes from a pending latch that captures an edge and is then masked by the current flags. The latch is cleared by bus initialization or by interrupt acknowledge. A `mode` input selects one of two behaviours. In gated mode (`mode`=0), the latch sets on a rising edge of the AND of ready and enable. The output is the latch masked by both flags. In ready-clocked mode (`mode`=1), the latch loads the enable bit when ready rises. The output is masked by enable only, so a request that is already pending survives when ready drops.

Top module: `csr_irq`

## Requirements
- R1: While `sel` is high, `rdata` shows error at bit 15, ready at bit 7, enable at bit 6 and start at bit 0, with every other bit 0. While `sel` is low, `rdata` is 0.
- R2: A write (`sel` and `wr` high) changes only enable (from `wdata[6]`) and start (from `wdata[0]`). Ready and error always follow `dev_ready` and `dev_error`.
- R3: Writing start as 1 makes bit 0 read 1 and `go_pulse` go high for exactly the cycle after the write edge. Both return to 0 one clock later unless start is written as 1 again.
- R4: In gated mode, the pending latch sets when (ready AND enable) goes from 0 to 1, measured against its value at the previous clock. This includes enable being written to 1 while ready is already high.
- R5: In gated mode, `irq` equals pending AND ready AND enable, so dropping either flag removes the request in the same cycle.
- R6: In ready-clocked mode, a rising edge of ready loads the pending latch with the current enable bit. A rising edge of enable alone never sets it.
- R7: In ready-clocked mode, `irq` equals pending AND enable. Dropping ready neither clears nor masks a pending request. Dropping enable masks it, and raising enable again restores it without a new edge.
- R8: `iack` clears the pending latch at the next edge and wins over a set edge in the same cycle.
- R9: `init` clears enable, start and the pending latch. It wins over a write and over a set edge in the same cycle.
- R10: After `rst`, enable, start and pending are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Bus initialization, synchronous |
| mode | input | 1 | 0 = gated, 1 = ready-clocked |
| sel | input | 1 | Register address hit |
| wr | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| dev_ready | input | 1 | Device ready status |
| dev_error | input | 1 | Device error summary |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| go_pulse | output | 1 | One-cycle start pulse to device |

## Verification
Flag changes and the pending latch take effect at the edge where the stimulus is sampled. Masking of `irq` by a falling ready or enable is combinational and shows in the same cycle. A write of enable therefore reaches `irq` in gated mode one edge after the write edge, because the AND edge is seen only once enable is registered. A ready edge reaches `irq` at the edge that samples it. The bench drives inputs on the falling clock edge and samples one nanosecond after the rising edge. It advances a requirement-based reference model at each rising edge, so every expectation is compared in the cycle it is due. A sweep covers every three-step pattern of ready, enable writes and clears in both modes.

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          mode,
  input  logic          sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          dev_ready,
  input  logic          dev_error,
  input  logic          iack,
  output logic          irq,
  output logic          go_pulse
);
  localparam int ERR_B = 15;
  localparam int RDY_B = 7;
  localparam int IE_B  = 6;
  localparam int GO_B  = 0;

  logic ie, go, pend, rdy_q, cond_q;

  wire wen      = sel & wr;
  wire cond     = dev_ready & ie;
  wire rdy_rise = dev_ready & ~rdy_q;
  wire clr      = init | iack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie <= 1'b0; go <= 1'b0; pend <= 1'b0;
      rdy_q <= 1'b0; cond_q <= 1'b0;
    end else begin
      rdy_q  <= dev_ready;
      cond_q <= cond;
      if (init) begin
        ie <= 1'b0;
        go <= 1'b0;
      end else begin
        if (wen) ie <= wdata[IE_B];
        go <= wen & wdata[GO_B];
      end
      if (clr)
        pend <= 1'b0;
      else if (mode) begin
        if (rdy_rise) pend <= ie;
      end else if (cond & ~cond_q)
        pend <= 1'b1;
    end
  end

  assign irq      = pend & ie & (mode | dev_ready);
  assign go_pulse = go;

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[ERR_B] = dev_error;
      rdata[RDY_B] = dev_ready;
      rdata[IE_B]  = ie;
      rdata[GO_B]  = go;
    end
  end

  // R3
  go_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
    (go_pulse && !(wen && wdata[GO_B])) |=> !go_pulse);
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (iack || init) |=> !irq);
  // R9
  init_flags_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> (!rdata[IE_B] && !go_pulse));
  // R5
  gated_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && !(dev_ready && rdata[IE_B] == 1'b1 || !sel && dev_ready && ie)) |-> !irq);
  // R7
  held_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && pend && ie && !clr) |=> pend);
  // R6
  en_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && !pend && !rdy_rise) |=> !pend);
endmodule

// File: tb/tb_csr_irq.sv
module tb_csr_irq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, init, mode, sel, wr, dev_ready, dev_error, iack;
  logic [15:0] wdata, rdata;
  logic irq, go_pulse;

  csr_irq #(.DW(16)) dut (.clk(clk), .rst(rst), .init(init), .mode(mode), .sel(sel),
    .wr(wr), .wdata(wdata), .rdata(rdata), .dev_ready(dev_ready), .dev_error(dev_error),
    .iack(iack), .irq(irq), .go_pulse(go_pulse));

  int checks = 0, errors = 0;
  logic m_ie, m_lat, m_rq, m_cq;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    init = 0; sel = 0; wr = 0; wdata = '0; iack = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle(); rst = 1; dev_ready = 0; dev_error = 0;
    @(posedge clk); #1;
    @(negedge clk); rst = 0;
    m_ie = 0; m_lat = 0; m_rq = 0; m_cq = 0;
  endtask

  // one modelled cycle: inputs applied at negedge, model advanced at posedge
  task automatic step(input logic rdy, input logic w, input logic wv, input logic ia, input logic in);
    logic n_ie, n_lat, cond;
    @(negedge clk);
    sel = 1; wr = w; wdata = {9'b0, wv, 6'b0}; dev_ready = rdy; iack = ia; init = in;
    cond = rdy & m_ie;
    n_ie = in ? 1'b0 : (w ? wv : m_ie);
    if (ia | in) n_lat = 1'b0;
    else if (mode) n_lat = (rdy & !m_rq) ? m_ie : m_lat;
    else n_lat = (cond & !m_cq) ? 1'b1 : m_lat;
    @(posedge clk); #1;
    m_ie = n_ie; m_lat = n_lat; m_rq = rdy; m_cq = cond;
    if (mode) chk("R6 R7 R8 R9 irq", {15'b0, irq}, {15'b0, m_lat & m_ie});
    else      chk("R4 R5 R8 R9 irq", {15'b0, irq}, {15'b0, m_lat & m_ie & rdy});
    chk("R1 R2 rdata", rdata, {8'b0, rdy, m_ie, 6'b0});
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mode = 0;
    do_reset();
    #1;
    chk("R10 irq", {15'b0, irq}, 16'h0);
    chk("R10 go_pulse", {15'b0, go_pulse}, 16'h0);
    chk("R1 unselected", rdata, 16'h0);
    sel = 1;
    #1 chk("R10 rdata", rdata, 16'h0);

    // R1 status readback
    @(negedge clk); dev_error = 1; dev_ready = 1;
    #1 chk("R1 err+rdy", rdata, 16'h8080);
    // R2 write cannot touch read-only bits
    @(negedge clk); dev_error = 0; dev_ready = 0; wr = 1; wdata = 16'h8080;
    @(posedge clk); #1; wr = 0;
    chk("R2 ro bits", rdata, 16'h0000);
    // R3 start pulse
    @(negedge clk); wr = 1; wdata = 16'h0001;
    @(posedge clk); #1;
    chk("R3 pulse hi", {15'b0, go_pulse}, 16'h1);
    chk("R3 bit0 hi", rdata, 16'h0001);
    @(negedge clk); wr = 0;
    @(posedge clk); #1;
    chk("R3 pulse lo", {15'b0, go_pulse}, 16'h0);
    chk("R3 bit0 lo", rdata, 16'h0000);
    // R9 init beats write
    @(negedge clk); wr = 1; wdata = 16'h0041; init = 1;
    @(posedge clk); #1;
    chk("R9 init over write", rdata, 16'h0000);
    chk("R9 init go", {15'b0, go_pulse}, 16'h0);

    // exhaustive 3-step sweep in both modes
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4096; s++) begin
        mode = md[0];
        do_reset();
        // preset enable first on half of patterns
        step(1'b0, s[0] ^ s[5], 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
          logic [3:0] b;
          b = 4'(s >> (4 * k));
          step(b[0], b[1], b[2], b[3] & (k != 2), b[3] & (k == 2));
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule